// File: doc/BRIEF.md
# Periodic Reload Timer with Two-Level Interrupt Gating

This block is an 8-bit down-counting timer that raises an interrupt at a fixed period. Software writes a reload value, picks a count source and sets the run bit. On the first cycle after run goes high, the counter loads the reload value. Each tick of the chosen source then lowers the counter by one. When a tick arrives with the counter at zero, a request flag is set and the counter reloads in the same cycle. The period is therefore (reload + 1) source ticks.

The default count source is the instruction clock, which is the system clock divided by three. Any other source code counts single-cycle pulses on an external tick input. The request flag stays set until the CPU tests it with a test-and-clear strobe. That strobe also reports the flag's value so that the CPU can skip its next instruction. The interrupt output is asserted only while the flag, a per-timer enable bit and a global enable bit are all 1.

Top module: `period_timer`

## Requirements
- R1: After reset, every register reads 0, and the request flag and the interrupt output are 0.
- R2: Register map at the 2-bit address: 0 is control (4 bits), 1 is reload (8 bits), 2 is interrupt control (4 bits, bit 2 is the timer enable), 3 is global enable (bit 0). Reads return the stored value zero-extended to 8 bits. In the control register, bit 3 is the auto-stop select (stored and read back only), bit 2 is run, and bits 1:0 are the source.
- R3: With source 00, a tick occurs every third system clock while running, and never on two consecutive cycles.
- R4: A control write that sets run takes effect at write edge W. The counter loads at W+1, and the first underflow sets the flag at W+3(reload+1)+1. Later underflows follow every 3(reload+1) cycles.
- R5: `tst_flag_o` shows the request flag while a test-and-clear strobe is high. The strobe clears the flag at the next edge.
- R6: While run is 0 the counter holds, no tick is produced, and the flag is not set.
- R7: `irq_o` is 1 exactly when the flag, the timer enable (interrupt control bit 2) and the global enable (bit 0) are all 1.
- R8: Setting run again after a stop reloads the counter, so the period restarts in full rather than resuming from the held count.
- R9: If an underflow and a test-and-clear strobe occur in the same cycle, the flag is 1 after that edge.
- R10: A source code other than 00 counts only the pulses on `ext_tick_i`, one decrement per high cycle. The divider is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| ext_tick_i | input | 1 | External count pulse for source codes other than 00 |
| tst_clr_i | input | 1 | Test-and-clear strobe for the request flag |
| tst_flag_o | output | 1 | Current request flag, reported to the tester |
| irq_o | output | 1 | Gated interrupt request |

## Verification
A write reaches its register one edge after the strobe. The counter loads one edge after run rises. With the divider, the first flag appears 3(reload+1)+1 edges after the run write, and each later flag follows 3(reload+1) edges after the one before. A clear or a gate change shows on the outputs one edge after its strobe. The driver tags each expected flag and interrupt value with the absolute edge number at which it is due, including the edge just before each due set. The monitor samples at falling edges and compares only at those exact edge numbers. Read data and `tst_flag_o` are combinational and are checked in the same cycle the address or strobe is applied.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CTRL_W   = 4;
  localparam int unsigned IEN_W    = 4;
  localparam int unsigned SRC_W    = 2;
  localparam int unsigned RUN_BIT  = 2;
  localparam int unsigned IEN_BIT  = 2;
  localparam int unsigned GIE_BIT  = 0;
  localparam int unsigned PRE_DIV  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_IEN    = 2'd2;
  localparam logic [ADDR_W-1:0] A_GIE    = 2'd3;

  localparam logic [SRC_W-1:0] SRC_INSTR = 2'b00;
endpackage

// File: rtl/period_timer_regs.sv
module period_timer_regs
  import period_timer_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              run_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [DW-1:0]     reload_o,
  output logic              ien_o,
  output logic              gie_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]     rld_q, rld_d;
  logic [IEN_W-1:0]  ien_q, ien_d;
  logic              gie_q, gie_d;

  always_comb begin
    ctrl_d = ctrl_q;
    rld_d  = rld_q;
    ien_d  = ien_q;
    gie_d  = gie_q;
    if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL:   ctrl_d = wr_data_i[CTRL_W-1:0];
        A_RELOAD: rld_d  = wr_data_i;
        A_IEN:    ien_d  = wr_data_i[IEN_W-1:0];
        default:  gie_d  = wr_data_i[GIE_BIT];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rld_q  <= '0;
      ien_q  <= '0;
      gie_q  <= 1'b0;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_d;
      rld_q  <= rld_d;
      ien_q  <= ien_d;
      gie_q  <= gie_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL:   rd_data_o[CTRL_W-1:0] = ctrl_q;
      A_RELOAD: rd_data_o             = rld_q;
      A_IEN:    rd_data_o[IEN_W-1:0]  = ien_q;
      default:  rd_data_o[GIE_BIT]    = gie_q;
    endcase
  end

  assign run_o    = ctrl_q[RUN_BIT];
  assign src_o    = ctrl_q[SRC_W-1:0];
  assign reload_o = rld_q;
  assign ien_o    = ien_q[IEN_BIT];
  assign gie_o    = gie_q;
endmodule

// File: rtl/period_timer_presc.sv
module period_timer_presc
  import period_timer_pkg::*;
#(
  parameter int unsigned DIV = PRE_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             ext_tick_i,
  output logic             tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] psc_q, psc_d;
  logic          active;
  logic          div_tick;

  assign active   = run_i && !load_i;
  assign div_tick = (psc_q == LAST);

  always_comb begin
    if (!active)       psc_d = '0;
    else if (div_tick) psc_d = '0;
    else               psc_d = psc_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_d;
  end

  assign tick_o = active && ((src_i == SRC_INSTR) ? div_tick : ext_tick_i);
endmodule

// File: rtl/period_timer_core.sv
module period_timer_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic         load_o,
  output logic         underflow_o,
  output logic [W-1:0] cnt_o
);
  logic         run_prev_q;
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign load_o      = run_i && !run_prev_q;
  assign underflow_o = tick_i && (cnt_q == '0);
  assign cnt_en      = load_o || tick_i;

  always_comb begin
    if (load_o || underflow_o) cnt_d = reload_i;
    else                       cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_prev_q <= 1'b0;
    else         run_prev_q <= run_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/period_timer_flag.sv
module period_timer_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ien_i && gie_i;
endmodule

// File: rtl/period_timer.sv
module period_timer
  import period_timer_pkg::*;
#(
  parameter int unsigned CNT_W = DATA_W,
  parameter int unsigned DIV   = PRE_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              ext_tick_i,
  input  logic              tst_clr_i,
  output logic              tst_flag_o,
  output logic              irq_o
);
  logic             run;
  logic [SRC_W-1:0] src;
  logic [CNT_W-1:0] reload;
  logic             ien;
  logic             gie;
  logic             load;
  logic             tick;
  logic             underflow;
  logic [CNT_W-1:0] cnt;
  logic             flag;

  period_timer_regs #(.DW(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .run_o(run), .src_o(src), .reload_o(reload), .ien_o(ien), .gie_o(gie)
  );

  period_timer_presc #(.DIV(DIV)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .load_i(load),
    .src_i(src), .ext_tick_i(ext_tick_i), .tick_o(tick)
  );

  period_timer_core #(.W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(tick),
    .reload_i(reload), .load_o(load), .underflow_o(underflow), .cnt_o(cnt)
  );

  period_timer_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(underflow), .clr_i(tst_clr_i),
    .ien_i(ien), .gie_i(gie), .flag_o(flag), .irq_o(irq_o)
  );

  assign tst_flag_o = flag;
endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk
  import period_timer_pkg::*;
#(
  parameter int unsigned CNT_W = DATA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic [SRC_W-1:0] src,
  input logic             tick,
  input logic             underflow,
  input logic [CNT_W-1:0] cnt,
  input logic             tst_clr_i,
  input logic             tst_flag_o,
  input logic             ien,
  input logic             gie,
  input logic             irq_o
);
  p_div_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && src == SRC_INSTR && tick) |=> !tick);

  p_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow |=> tst_flag_o);

  p_flag_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tst_clr_i && !underflow) |=> !tst_flag_o);

  p_stop_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(cnt));

  p_stop_notick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !tick);

  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien || !gie || !tst_flag_o) |-> !irq_o);

  p_collide_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow && tst_clr_i) |=> tst_flag_o);
endmodule

bind period_timer period_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .src(src), .tick(tick),
  .underflow(underflow), .cnt(cnt), .tst_clr_i(tst_clr_i),
  .tst_flag_o(tst_flag_o), .ien(ien), .gie(gie), .irq_o(irq_o)
);

// File: tb/period_timer_tb_top.sv
module period_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic [1:0] wr_addr_i;
  logic [7:0] wr_data_i;
  logic [1:0] rd_addr_i;
  logic [7:0] rd_data_o;
  logic       ext_tick_i;
  logic       tst_clr_i;
  logic       tst_flag_o;
  logic       irq_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    int    due;
    logic  flag;
    logic  irq;
    string tag;
  } exp_t;
  exp_t q[$];

  period_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .ext_tick_i(ext_tick_i), .tst_clr_i(tst_clr_i), .tst_flag_o(tst_flag_o),
    .irq_o(irq_o)
  );

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int due, input logic f, input logic i, input string tag);
    exp_t e;
    e.due = due; e.flag = f; e.irq = i; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares flag/irq at the exact edge each item is due.
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check(e.due == cyc, {e.tag, " (missed slot)"}, cyc, e.due);
      check(tst_flag_o === e.flag, {e.tag, " flag"}, int'(tst_flag_o), int'(e.flag));
      check(irq_o === e.irq, {e.tag, " irq"}, int'(irq_o), int'(e.irq));
    end
  end

  // Called at a falling edge; the write lands on the next rising edge, returned in w.
  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int w);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    w = cyc + 1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clr_pulse(output int w);
    tst_clr_i = 1'b1;
    w = cyc + 1;
    @(negedge clk_i);
    tst_clr_i = 1'b0;
  endtask

  task automatic ext_pulse();
    ext_tick_i = 1'b1;
    @(negedge clk_i);
    ext_tick_i = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk_i);
  endtask

  task automatic rd_check(input logic [1:0] a, input int exp, input string tag);
    rd_addr_i = a;
    #0.5;
    check(rd_data_o === 8'(exp), tag, int'(rd_data_o), exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired at edge %0d: actual 1 expected 0", cyc);
    finish_run();
  end

  initial begin
    int w, c0, cs;
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    rd_addr_i = '0; ext_tick_i = 1'b0; tst_clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 4; a++) rd_check(2'(a), 0, "R1 register reset");
    check(tst_flag_o === 1'b0, "R1 flag reset", int'(tst_flag_o), 0);
    check(irq_o === 1'b0, "R1 irq reset", int'(irq_o), 0);

    // R2 map and readback, auto-stop bit stored only
    wr(2'd0, 8'hF8, w);
    rd_check(2'd0, 8'h08, "R2 control readback (auto-stop bit)");
    wr(2'd1, 8'd4, w);
    rd_check(2'd1, 4, "R2 reload readback");
    wr(2'd2, 8'hFB, w);
    rd_check(2'd2, 8'h0B, "R2 interrupt control readback");
    wr(2'd2, 8'h00, w);
    wr(2'd3, 8'hFE, w);
    rd_check(2'd3, 0, "R2 global enable uses bit 0 only");

    // R3/R4 divided source, reload 4: first flag at W+16
    wr(2'd0, 8'h04, c0);
    push(c0 + 15, 1'b0, 1'b0, "R4 no flag before first period");
    push(c0 + 16, 1'b1, 1'b0, "R3 R4 first underflow, R7 gated off");
    wait_to(c0 + 17);

    // R7 both enables
    wr(2'd3, 8'h01, w);
    push(w, 1'b1, 1'b0, "R7 global alone insufficient");
    wr(2'd2, 8'h04, w);
    push(w, 1'b1, 1'b1, "R7 both enables");
    wait_to(w);

    // R5 test and clear
    check(tst_flag_o === 1'b1, "R5 flag reported", int'(tst_flag_o), 1);
    clr_pulse(w);
    push(w, 1'b0, 1'b0, "R5 clear by test");
    wait_to(w);
    push(c0 + 30, 1'b0, 1'b0, "R4 second period not early");
    push(c0 + 31, 1'b1, 1'b1, "R4 second underflow");
    wait_to(c0 + 32);
    wr(2'd3, 8'h00, w);
    push(w, 1'b1, 1'b0, "R7 global off masks irq");
    wait_to(w);

    // R6 stop holds
    wr(2'd0, 8'h00, cs);
    clr_pulse(w);
    push(w, 1'b0, 1'b0, "R6 cleared after stop");
    push(cs + 40, 1'b0, 1'b0, "R6 no underflow while stopped");
    wait_to(cs + 41);

    // R8 restart reloads: full period again
    wr(2'd0, 8'h04, c0);
    push(c0 + 15, 1'b0, 1'b0, "R8 restart full period");
    push(c0 + 16, 1'b1, 1'b0, "R8 restart underflow");
    wait_to(c0 + 17);

    // R9 collision with reload 0 (underflow every 3 edges)
    wr(2'd0, 8'h00, w);
    clr_pulse(w);
    wr(2'd1, 8'd0, w);
    wr(2'd0, 8'h04, c0);
    push(c0 + 3, 1'b0, 1'b0, "R4 reload 0 not early");
    push(c0 + 4, 1'b1, 1'b0, "R4 reload 0 underflow");
    wait_to(c0 + 6);
    clr_pulse(w);
    push(c0 + 7, 1'b1, 1'b0, "R9 underflow wins over clear");
    clr_pulse(w);
    push(c0 + 8, 1'b0, 1'b0, "R5 plain clear");
    push(c0 + 9, 1'b0, 1'b0, "R3 no tick on next cycle");
    push(c0 + 10, 1'b1, 1'b0, "R3 next divided underflow");
    wait_to(c0 + 11);

    // R10 external source, reload 2
    wr(2'd0, 8'h00, w);
    clr_pulse(w);
    wr(2'd1, 8'd2, w);
    wr(2'd0, 8'h05, c0);
    push(c0 + 19, 1'b0, 1'b0, "R10 divider ignored");
    wait_to(c0 + 20);
    ext_pulse();
    wait_to(c0 + 25);
    ext_pulse();
    wait_to(c0 + 30);
    push(c0 + 30, 1'b0, 1'b0, "R10 two pulses no underflow");
    push(c0 + 31, 1'b1, 1'b0, "R10 third pulse underflows");
    ext_pulse();
    wait_to(c0 + 33);

    while (q.size() > 0) @(negedge clk_i);
    finish_run();
  end
endmodule